// File: doc/BRIEF.md
# Receiver-Detect Link-Up Sequencer

This controller sits on the MAC side of a multi-lane serial PHY interface. It takes the link from reset to the point where polling can begin. All lanes are driven in lockstep. While reset is held, it keeps the transmitters electrically idle in the P1 power state. After reset is released, it waits for the PHY to drop its reset-complete status. It then requests receiver detection and reads the completion code the PHY returns. If no receiver is found, it pauses and tries again. Once a receiver is found, it moves the PHY to P0 and waits for the acknowledgement before it signals that polling may start.

The link layer controls the block through an active-low reset and a 4-bit state request. A request of 4'b0000 means Reset. The block's other outputs are the current sequencer state, a receiver-detected flag, a polling-entry indication and a sticky watchdog error. Training sets, equalization, speed change and data encoding are handled by other blocks.

Top module: `linkup_sequencer`

## Requirements
- R1: PowerDown uses the encoding P0=2'b00, P0s=2'b01, P1=2'b10, P2=2'b11, with lane i in bits [2i+1:2i]. Every lane carries P1 in the reset, PHY-wait, detect and retry states (state codes 0, 1, 2, 3).
- R2: TxElecIdle is high on every lane in every state except polling (code 5), where it is low.
- R3: While rst_n is low, or while state_req is 4'b0000, the block stays in reset (code 0) with the detect request low and rx_detected, polling_entry and wdog_err low.
- R4: After reset is released, the block waits in PHY-wait (code 1) without requesting detection for as long as any lane's PhyStatus is high. It enters detect (code 2) on the first edge that sees every lane low.
- R5: In detect, the detect request is high on every lane. Completion requires PhyStatus high on all lanes in the same cycle. A pulse on only some lanes leaves the block in detect.
- R6: A completion in which every lane's RxStatus is 3'b011 (receiver present) sets rx_detected and drops the detect request on the next cycle. The request is not raised again until the block has passed through reset.
- R7: After a receiver is detected, PowerDown changes to P0 on every lane (code 4) while polling_entry stays low.
- R8: polling_entry rises, with state code 5, on the cycle after PhyStatus is high on all lanes in code 4, and not earlier.
- R9: A completion carrying any other RxStatus (3'b000 means no receiver) moves the block to retry (code 3). It holds the detect request low there for exactly RETRY_CYCLES cycles and then returns to detect.
- R10: A state request of 4'b0000 in any state returns the block to reset (code 0) at the next clock edge.
- R11: If PhyStatus does not complete on all lanes within WDOG_CYCLES cycles of entering detect or the P0 change, wdog_err goes high. It stays high until the block is back in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset from the link layer |
| state_req | input | 4 | Link-layer state request; 4'b0000 means Reset |
| phy_status | input | LANES | Per-lane PHY completion status |
| rx_status | input | 3*LANES | Per-lane receive status code |
| power_down | output | 2*LANES | Per-lane power state |
| tx_elec_idle | output | LANES | Per-lane transmitter idle |
| tx_detect_rx | output | LANES | Per-lane receiver-detect request |
| cur_state | output | 3 | Sequencer state code |
| rx_detected | output | 1 | A receiver was found |
| polling_entry | output | 1 | P0 acknowledged; polling may begin |
| wdog_err | output | 1 | PhyStatus completion timed out |

## Verification
The assertions assume that the PHY raises PhyStatus on all lanes together, for one cycle per completion, and only when a detect request or a power change is pending. The exception is the reset-time status, which is held high until after release. The stimulus is a bench PHY model. It drives completions only from those waiting states, at randomly chosen latencies well below the watchdog limit, and it keeps each pulse to a single cycle. Partial-lane pulses, aborts and a never-answering PHY are injected as directed cases.

// File: rtl/lu_pkg.sv
package lu_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_PHY_WAIT = 3'd1,
    ST_DETECT   = 3'd2,
    ST_RETRY    = 3'd3,
    ST_GO_P0    = 3'd4,
    ST_POLLING  = 3'd5
  } lu_state_e;

  typedef enum logic [1:0] {
    PD_P0  = 2'b00,
    PD_P0S = 2'b01,
    PD_P1  = 2'b10,
    PD_P2  = 2'b11
  } pd_e;

  localparam logic [3:0] REQ_RESET    = 4'b0000;
  localparam logic [2:0] RXST_PRESENT = 3'b011;
endpackage

// File: rtl/lu_cycle_timer.sv
module lu_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (en && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lu_status_merge.sv
module lu_status_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   phy_status,
  input  logic [3*LANES-1:0] rx_status,
  output logic               status_all,
  output logic               status_any,
  output logic               rx_all_present
);
  logic [LANES-1:0] present;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign present[i] = (rx_status[3*i +: 3] == lu_pkg::RXST_PRESENT);
  end

  assign status_all     = &phy_status;
  assign status_any     = |phy_status;
  assign rx_all_present = &present;
endmodule

// File: rtl/lu_lane_fanout.sv
module lu_lane_fanout #(
  parameter int LANES = 4
) (
  input  logic [1:0]         pd_cmd,
  input  logic               idle_cmd,
  input  logic               det_cmd,
  output logic [2*LANES-1:0] power_down,
  output logic [LANES-1:0]   tx_elec_idle,
  output logic [LANES-1:0]   tx_detect_rx
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign power_down[2*i +: 2] = pd_cmd;
    assign tx_elec_idle[i]      = idle_cmd;
    assign tx_detect_rx[i]      = det_cmd;
  end
endmodule

// File: rtl/linkup_sequencer.sv
module linkup_sequencer #(
  parameter int LANES        = 4,
  parameter int RETRY_CYCLES = 16,
  parameter int WDOG_CYCLES  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           state_req,
  input  logic [LANES-1:0]     phy_status,
  input  logic [3*LANES-1:0]   rx_status,
  output logic [2*LANES-1:0]   power_down,
  output logic [LANES-1:0]     tx_elec_idle,
  output logic [LANES-1:0]     tx_detect_rx,
  output logic [2:0]           cur_state,
  output logic                 rx_detected,
  output logic                 polling_entry,
  output logic                 wdog_err
);
  import lu_pkg::*;

  lu_state_e state, nxt;
  logic st_all, st_any, rx_ok;
  logic retry_done, wd_done, waiting;
  logic [1:0] pd_cmd;
  logic rxdet_q, wderr_q;

  lu_status_merge #(.LANES(LANES)) u_merge (
    .phy_status(phy_status), .rx_status(rx_status),
    .status_all(st_all), .status_any(st_any), .rx_all_present(rx_ok)
  );

  lu_cycle_timer #(.LIMIT(RETRY_CYCLES)) u_retry (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_RETRY), .en(state == ST_RETRY), .done(retry_done)
  );

  assign waiting = (state == ST_DETECT) || (state == ST_GO_P0);

  lu_cycle_timer #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk(clk), .rst_n(rst_n),
    .clr(!waiting || st_all), .en(waiting), .done(wd_done)
  );

  always_comb begin
    nxt = state;
    if (state_req == REQ_RESET) begin
      nxt = ST_RESET;
    end else begin
      case (state)
        ST_RESET:    nxt = ST_PHY_WAIT;
        ST_PHY_WAIT: if (!st_any) nxt = ST_DETECT;
        ST_DETECT:   if (st_all) nxt = rx_ok ? ST_GO_P0 : ST_RETRY;
        ST_RETRY:    if (retry_done) nxt = ST_DETECT;
        ST_GO_P0:    if (st_all) nxt = ST_POLLING;
        ST_POLLING:  nxt = ST_POLLING;
        default:     nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RESET;
      rxdet_q <= 1'b0;
      wderr_q <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == ST_RESET)
        rxdet_q <= 1'b0;
      else if (state == ST_DETECT && st_all && rx_ok)
        rxdet_q <= 1'b1;
      if (nxt == ST_RESET)
        wderr_q <= 1'b0;
      else if (waiting && wd_done && !st_all)
        wderr_q <= 1'b1;
    end
  end

  assign pd_cmd = (state == ST_GO_P0 || state == ST_POLLING) ? PD_P0 : PD_P1;

  lu_lane_fanout #(.LANES(LANES)) u_fan (
    .pd_cmd(pd_cmd),
    .idle_cmd(state != ST_POLLING),
    .det_cmd(state == ST_DETECT),
    .power_down(power_down),
    .tx_elec_idle(tx_elec_idle),
    .tx_detect_rx(tx_detect_rx)
  );

  assign cur_state     = state;
  assign rx_detected   = rxdet_q;
  assign polling_entry = (state == ST_POLLING);
  assign wdog_err      = wderr_q;

  AST_REQ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_req == REQ_RESET) |=> (cur_state == ST_RESET)); // R10

  AST_WAIT_PHY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_PHY_WAIT && st_any) |=> (tx_detect_rx == '0)); // R4

  AST_DETECT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_DETECT && st_all && rx_ok && state_req != REQ_RESET)
    |=> (rx_detected && tx_detect_rx == '0)); // R6

  AST_NO_REDETECT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_detected |-> (tx_detect_rx == '0)); // R6

  AST_RETRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_RETRY) |-> (tx_detect_rx == '0 && !rx_detected)); // R9

  AST_POLL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(polling_entry) |-> $past(cur_state == ST_GO_P0 && st_all)); // R8

  AST_P0_BEFORE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    polling_entry |-> $past(power_down[1:0] == PD_P0)); // R7

  AST_IDLE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_detect_rx[0] || cur_state == ST_PHY_WAIT) |-> (tx_elec_idle == '1)); // R2
endmodule

// File: tb/tb_linkup_sequencer.sv
module tb_linkup_sequencer;
  localparam int L  = 4;
  localparam int RW = 5;
  localparam int WD = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] state_req;
  logic [L-1:0] phy_status;
  logic [3*L-1:0] rx_status;
  logic [2*L-1:0] power_down;
  logic [L-1:0] tx_elec_idle, tx_detect_rx;
  logic [2:0] cur_state;
  logic rx_detected, polling_entry, wdog_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;

  linkup_sequencer #(.LANES(L), .RETRY_CYCLES(RW), .WDOG_CYCLES(WD)) dut (
    .clk(clk), .rst_n(rst_n), .state_req(state_req),
    .phy_status(phy_status), .rx_status(rx_status),
    .power_down(power_down), .tx_elec_idle(tx_elec_idle),
    .tx_detect_rx(tx_detect_rx), .cur_state(cur_state),
    .rx_detected(rx_detected), .polling_entry(polling_entry),
    .wdog_err(wdog_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [2*L-1:0] exp_pd(input int st);
    return (st == 4 || st == 5) ? {L{2'b00}} : {L{2'b10}};
  endfunction
  function automatic logic [L-1:0] exp_idle(input int st);
    return (st == 5) ? '0 : '1;
  endfunction
  function automatic logic [L-1:0] exp_det(input int st);
    return (st == 2) ? '1 : '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int st);
    chk({req, " state"}, 32'(cur_state), 32'(st));
    chk("R1 power_down", 32'(power_down), 32'(exp_pd(st)));
    chk("R2 tx_elec_idle", 32'(tx_elec_idle), 32'(exp_idle(st)));
    chk({req, " tx_detect_rx"}, 32'(tx_detect_rx), 32'(exp_det(st)));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; state_req = 4'b0000; phy_status = '1; rx_status = '0;
    repeat (3) tick();
    chk_state("R3", 0);
    chk("R3 flags", {29'd0, rx_detected, polling_entry, wdog_err}, 32'd0);
  endtask

  task automatic release_phy(input int lat);
    rst_n = 1'b1; state_req = 4'b0001;
    tick();
    for (int k = 0; k < lat; k++) begin
      chk_state("R4", 1);
      tick();
    end
    phy_status = '0;
    tick();
    chk_state("R5", 2);
  endtask

  task automatic completion(input bit present);
    phy_status = '1;
    rx_status = present ? {L{3'b011}} : {L{3'b000}};
    tick();
    phy_status = '0; rx_status = '0;
  endtask

  task automatic run_link(input int lat, input int nfail, input bit partial, input bit abort_it);
    int cnt;
    release_phy(lat);
    if (partial) begin
      phy_status = L'(1);
      tick();
      phy_status = '0;
      chk_state("R5 partial", 2);
    end
    if (abort_it) begin
      state_req = 4'b0000;
      tick();
      chk_state("R10", 0);
      return;
    end
    for (int f = 0; f < nfail; f++) begin
      repeat (lat) tick();
      chk("R5 request held", 32'(tx_detect_rx), 32'(exp_det(2)));
      completion(1'b0);
      cnt = 0;
      chk_state("R9", 3);
      while (tx_detect_rx == '0 && cnt < 100) begin
        cnt++;
        tick();
      end
      chk("R9 retry length", 32'(cnt), 32'(RW));
      chk("R9 back to detect", 32'(cur_state), 32'd2);
    end
    repeat (lat) tick();
    completion(1'b1);
    chk_state("R6", 4);
    chk("R6 rx_detected", 32'(rx_detected), 32'd1);
    chk("R7 polling low", 32'(polling_entry), 32'd0);
    for (int k = 0; k < lat; k++) begin
      tick();
      chk("R8 no early poll", 32'(polling_entry), 32'd0);
      chk("R6 no redetect", 32'(tx_detect_rx), 32'd0);
    end
    phy_status = '1;
    tick();
    phy_status = '0;
    chk_state("R8", 5);
    chk("R8 polling_entry", 32'(polling_entry), 32'd1);
    repeat (3) tick();
    chk("R6 still no redetect", 32'(tx_detect_rx), 32'd0);
    chk("R11 no timeout", 32'(wdog_err), 32'd0);
    state_req = 4'b0000;
    tick();
    chk_state("R10 from polling", 0);
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'd20250601);
    rst_n = 1'b0; state_req = 4'b0000; phy_status = '1; rx_status = '0;
    tick();
    do_reset();
    // directed: no retries, immediate PHY
    run_link(0, 0, 1'b0, 1'b0);
    do_reset();
    run_link(1, 2, 1'b1, 1'b0);
    for (int it = 0; it < 20; it++) begin
      do_reset();
      run_link(int'($urandom_range(0, 6)), int'($urandom_range(0, 3)),
               1'(($urandom_range(0, 1))), ($urandom_range(0, 5) == 0));
    end
    // directed: PHY never answers detect
    do_reset();
    release_phy(2);
    repeat (WD - 1) tick();
    chk("R11 before limit", 32'(wdog_err), 32'd0);
    tick();
    chk("R11 timeout", 32'(wdog_err), 32'd1);
    state_req = 4'b0000;
    tick();
    chk("R11 cleared in reset", 32'(wdog_err), 32'd0);
    chk_state("R10 abort detect", 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule